// File: doc/BRIEF.md
# Calibration update sequencer

This block recomputes the derived output code of a converter channel each time one of that channel's three calibration inputs is written: the raw input code, the gain word or the offset word. The register file that holds those words sits outside the block. When a write completes, the storage raises a one-cycle completion strobe together with a mask of the channels it touched. The sequencer then reads each channel's operands through a channel-select port and returns the computed code with a one-cycle write strobe.

The calculation passes through three timed stages whose lengths are parameters in clock cycles. At 100 MHz the defaults are 60, 60 and 30 cycles, which give 600 ns, 600 ns and 300 ns. The first stage captures a channel's operands and runs once for each channel in the mask, lowest index first. The second stage forms the scaled product. The third stage adds the offset, removes the mid-scale bias and clamps the result. The serial front end watches `stage1_busy` to hold off completion of its next write. A write that completes while first-stage work is still pending is refused and flagged, not queued.

The result is code = ((gain + 1) * x1 >> DW) + offset - 2^(DW-1), clamped to the range 0 to 2^DW - 1. With the default DW = 14, the bias is 8192 and the ceiling is 16383.

Top module: `calib_update_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `stage1_busy`, `pipe_busy`, `x2_we` and `wr_err` are all 0.
- R2: When `wr_done` is high with a non-zero `wr_mask` at a clock edge where `stage1_busy` is low, the write is accepted and `stage1_busy` is 1 in the following cycle. `pipe_busy` is 1 whenever `stage1_busy` is 1.
- R3: First-stage passes run back to back, one per set bit of `wr_mask`, in ascending channel order, each lasting S1_CYC cycles. For a mask with N bits set, `stage1_busy` is low again 1 + N*S1_CYC cycles after the accepting edge.
- R4: The k-th channel of an accepted mask, counting from 0, produces a one-cycle `x2_we` pulse 1 + (k+1)*S1_CYC + S2_CYC + S3_CYC cycles after the accepting edge. No other `x2_we` pulses occur.
- R5: `x2_data` equals ((gain + 1) * x1 >> DW) + offset - 2^(DW-1), clamped to 0 .. 2^DW - 1. `x2_ch` carries the channel index as a binary number.
- R6: A `wr_done` with a non-zero mask at an edge where `stage1_busy` is high raises `wr_err` for exactly the next cycle. Such a write adds no results and does not change the timing of the work in flight.
- R7: A write is accepted while only the second and third stages are busy. The results of the earlier write are still delivered unchanged and on time.
- R8: A channel's operands are sampled from `rd_x1`, `rd_gain` and `rd_ofs` at the edge where its first-stage pass begins. During that sampling cycle `rd_ch` holds the channel's index. Storage changes made after that edge do not affect the channel's result, and changes made before it do.
- R9: A `wr_done` with an all-zero mask is ignored. It causes no busy indication and no `wr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_done | input | 1 | One-cycle strobe: a write to x1, gain or offset has completed |
| wr_mask | input | NCH | Channels touched by the completed write |
| rd_ch | output | CHW | Channel whose operands are being read |
| rd_x1 | input | DW | Raw input code of channel `rd_ch` |
| rd_gain | input | DW | Gain word of channel `rd_ch` |
| rd_ofs | input | DW | Offset word of channel `rd_ch` |
| x2_we | output | 1 | One-cycle strobe: the derived code is ready |
| x2_ch | output | CHW | Channel of the derived code |
| x2_data | output | DW | Derived output code |
| stage1_busy | output | 1 | First-stage work is pending or running |
| pipe_busy | output | 1 | Some stage is active or work is pending |
| wr_err | output | 1 | One-cycle flag: a write was refused |

## Verification
The hardest state to reach is an operand capture for a late channel of a group write that overlaps a storage update. The update has to land after an earlier channel has been sampled but before the later one is. The stimulus issues a two-channel mask, waits a few cycles, and then rewrites both channels' storage. The first channel must keep its old operands and the second must pick up the new ones. Refused writes are aimed into random points of a busy first stage, and follow-on writes are issued in the first idle cycle of stage 1, so that they overlap stages 2 and 3 of the previous write. Every result is matched against an expected arrival cycle, channel and value computed by the bench.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   // Clamp a signed value into 0 .. hi.
   function automatic longint clamp_code(input longint v, input longint hi);
      if (v < 0)
         return 0;
      else if (v > hi)
         return hi;
      return v;
   endfunction

   // Number of pipeline stages and their indices.
   localparam int unsigned NUM_STG = 3;
   typedef enum int unsigned {
      STG_CAPTURE = 0,
      STG_SCALE   = 1,
      STG_FINISH  = 2
   } stage_e;

endpackage

// File: rtl/cal_lowest_pick.sv
module cal_lowest_pick #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);

   generate
      if (N == 1) begin : g_single
         assign idx = '0;
         assign any = req[0];
      end else begin : g_multi
         always_comb begin
            idx = '0;
            any = 1'b0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) begin
                  idx = IW'(i);
                  any = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cal_stage_tmr.sv
module cal_stage_tmr #(
   parameter int unsigned CYC = 60,
   localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic done
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= CW'(CYC - 1);
      end else if (done) begin
         active <= 1'b0;
      end else if (active) begin
         cnt <= cnt - CW'(1);
      end
   end

   assign done = active && (cnt == '0);

   // R3
   tmr_fell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> $past(done));

endmodule

// File: rtl/cal_arith.sv
module cal_arith #(
   parameter int unsigned DW = 14
) (
   input  logic [DW-1:0] m_x1,
   input  logic [DW-1:0] m_gain,
   output logic [DW-1:0] mul_hi,
   input  logic [DW-1:0] a_mul,
   input  logic [DW-1:0] a_ofs,
   output logic [DW-1:0] code
);
   import cal_seq_pkg::*;

   localparam longint BIAS = longint'(1) << (DW - 1);
   localparam longint TOP  = (longint'(1) << DW) - 1;

   logic [DW:0]     gain_p1;
   logic [2*DW-1:0] prod;
   longint          sum;
   longint          clipped;

   always_comb begin
      gain_p1 = {1'b0, m_gain} + (DW+1)'(1);
      prod    = (2*DW)'(gain_p1) * (2*DW)'(m_x1);
      mul_hi  = DW'(prod >> DW);
   end

   always_comb begin
      sum     = longint'(a_mul) + longint'(a_ofs) - BIAS;
      clipped = clamp_code(sum, TOP);
      code    = clipped[DW-1:0];
   end

endmodule

// File: rtl/calib_update_seq.sv
module calib_update_seq #(
   parameter int unsigned NCH    = 8,
   parameter int unsigned DW     = 14,
   parameter int unsigned S1_CYC = 60,
   parameter int unsigned S2_CYC = 60,
   parameter int unsigned S3_CYC = 30,
   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_done,
   input  logic [NCH-1:0] wr_mask,
   output logic [CHW-1:0] rd_ch,
   input  logic [DW-1:0]  rd_x1,
   input  logic [DW-1:0]  rd_gain,
   input  logic [DW-1:0]  rd_ofs,
   output logic           x2_we,
   output logic [CHW-1:0] x2_ch,
   output logic [DW-1:0]  x2_data,
   output logic           stage1_busy,
   output logic           pipe_busy,
   output logic           wr_err
);
   import cal_seq_pkg::*;

   initial begin
      if (S1_CYC < 1 || S2_CYC < 1 || S3_CYC < 1)
         $error("stage lengths must be at least one cycle");
      if (S2_CYC > S1_CYC || S3_CYC > S2_CYC)
         $error("later stages must not be longer than earlier ones");
      if (NCH < 1 || DW < 2)
         $error("bad channel count or data width");
   end

   function automatic int unsigned stg_len(input int unsigned s);
      case (s)
         STG_CAPTURE: return S1_CYC;
         STG_SCALE:   return S2_CYC;
         default:     return S3_CYC;
      endcase
   endfunction

   logic [NUM_STG-1:0] st_start, st_act, st_done;
   logic [NCH-1:0]     pend;
   logic [CHW-1:0]     pick_idx;
   logic               pick_any;
   logic               accept, reject;

   // Stage 1 operand capture
   logic [CHW-1:0] s1_ch;
   logic [DW-1:0]  s1_x1, s1_m, s1_c;
   // Stage 2 operands
   logic [CHW-1:0] s2_ch;
   logic [DW-1:0]  s2_x1, s2_m, s2_c;
   // Stage 3 operands
   logic [CHW-1:0] s3_ch;
   logic [DW-1:0]  s3_mul, s3_c;

   logic [DW-1:0]  mul_hi, code;

   cal_lowest_pick #(.N(NCH), .IW(CHW)) u_pick (
      .req (pend),
      .idx (pick_idx),
      .any (pick_any)
   );

   generate
      for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
         cal_stage_tmr #(.CYC(stg_len(s))) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (st_start[s]),
            .active (st_act[s]),
            .done   (st_done[s])
         );
      end
   endgenerate

   assign stage1_busy = st_act[STG_CAPTURE] | (|pend);
   assign pipe_busy   = stage1_busy | st_act[STG_SCALE] | st_act[STG_FINISH];
   assign accept      = wr_done && (|wr_mask) && !stage1_busy;
   assign reject      = wr_done && (|wr_mask) && stage1_busy;
   assign rd_ch       = pick_idx;

   always_comb begin
      st_start[STG_CAPTURE] = pick_any && (!st_act[STG_CAPTURE] || st_done[STG_CAPTURE]);
      st_start[STG_SCALE]   = st_done[STG_CAPTURE];
      st_start[STG_FINISH]  = st_done[STG_SCALE];
   end

   // Pending-channel mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= '0;
      else if (accept)
         pend <= wr_mask;
      else if (st_start[STG_CAPTURE])
         pend <= pend & ~(NCH'(1) << pick_idx);
   end

   // Operand registers along the pipe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_ch <= '0; s1_x1 <= '0; s1_m <= '0; s1_c <= '0;
         s2_ch <= '0; s2_x1 <= '0; s2_m <= '0; s2_c <= '0;
         s3_ch <= '0; s3_mul <= '0; s3_c <= '0;
      end else begin
         if (st_start[STG_CAPTURE]) begin
            s1_ch <= pick_idx;
            s1_x1 <= rd_x1;
            s1_m  <= rd_gain;
            s1_c  <= rd_ofs;
         end
         if (st_start[STG_SCALE]) begin
            s2_ch <= s1_ch;
            s2_x1 <= s1_x1;
            s2_m  <= s1_m;
            s2_c  <= s1_c;
         end
         if (st_start[STG_FINISH]) begin
            s3_ch  <= s2_ch;
            s3_mul <= mul_hi;
            s3_c   <= s2_c;
         end
      end
   end

   cal_arith #(.DW(DW)) u_arith (
      .m_x1   (s2_x1),
      .m_gain (s2_m),
      .mul_hi (mul_hi),
      .a_mul  (s3_mul),
      .a_ofs  (s3_c),
      .code   (code)
   );

   // Result and refusal outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x2_we   <= 1'b0;
         x2_ch   <= '0;
         x2_data <= '0;
         wr_err  <= 1'b0;
      end else begin
         x2_we  <= st_done[STG_FINISH];
         wr_err <= reject;
         if (st_done[STG_FINISH]) begin
            x2_ch   <= s3_ch;
            x2_data <= code;
         end
      end
   end

   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && (|wr_mask) && !stage1_busy) |=> stage1_busy);

   // R6
   reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_done && stage1_busy));

   // R3
   pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_start[STG_CAPTURE] |-> pend[rd_ch]);

   // R8
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_act[STG_CAPTURE] && !st_start[STG_CAPTURE]) |=> $stable(s1_x1) && $stable(s1_c));

   // R9
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && (wr_mask == '0) && !pipe_busy) |=> !stage1_busy && !wr_err);

endmodule

// File: tb/calib_update_seq_bench.sv
module calib_update_seq_bench;
   localparam int NCH = 8;
   localparam int DW  = 14;
   localparam int S1  = 60;
   localparam int S2  = 60;
   localparam int S3  = 30;
   localparam int CHW = 3;
   localparam int LIMIT = 150000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_done = 1'b0;
   logic [NCH-1:0] wr_mask = '0;
   logic [CHW-1:0] rd_ch;
   logic [DW-1:0]  rd_x1, rd_gain, rd_ofs;
   logic           x2_we;
   logic [CHW-1:0] x2_ch;
   logic [DW-1:0]  x2_data;
   logic           stage1_busy, pipe_busy, wr_err;

   logic [DW-1:0] mem_x1 [NCH];
   logic [DW-1:0] mem_m  [NCH];
   logic [DW-1:0] mem_c  [NCH];

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int q_cyc[$];
   int q_ch[$];
   int q_dat[$];
   int m_c, m_ch, m_d;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign rd_x1   = mem_x1[rd_ch];
   assign rd_gain = mem_m[rd_ch];
   assign rd_ofs  = mem_c[rd_ch];

   calib_update_seq #(.NCH(NCH), .DW(DW), .S1_CYC(S1), .S2_CYC(S2), .S3_CYC(S3)) u_calib_update_seq (
      .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .wr_mask(wr_mask), .rd_ch(rd_ch),
      .rd_x1(rd_x1), .rd_gain(rd_gain), .rd_ofs(rd_ofs), .x2_we(x2_we), .x2_ch(x2_ch),
      .x2_data(x2_data), .stage1_busy(stage1_busy), .pipe_busy(pipe_busy), .wr_err(wr_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int x2_ref(input int x1, input int m, input int c);
      longint p, s;
      p = ((longint'(m) + 1) * longint'(x1)) >> DW;
      s = p + longint'(c) - (longint'(1) << (DW - 1));
      if (s < 0) s = 0;
      if (s > (longint'(1) << DW) - 1) s = (longint'(1) << DW) - 1;
      return int'(s);
   endfunction

   // Result monitor: R4 timing, R3/R5 channel and value
   always @(negedge clk) begin
      if (rst_n && x2_we) begin
         if (q_cyc.size() == 0) begin
            chk(1'b0, "R4 unexpected result on channel", int'(x2_ch), -1);
         end else begin
            m_c = q_cyc.pop_front();
            m_ch = q_ch.pop_front();
            m_d = q_dat.pop_front();
            chk(cyc == m_c, "R4 result cycle", cyc, m_c);
            chk(int'(x2_ch) == m_ch, "R3 result channel order", int'(x2_ch), m_ch);
            chk(int'(x2_data) == m_d, "R5 result value", int'(x2_data), m_d);
         end
      end
   end

   always @(negedge clk) begin
      if (cyc > LIMIT) begin
         errors++;
         $display("FAIL R4 watchdog expired actual %0d expected below %0d", cyc, LIMIT);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // Drive one write; returns the accepting edge number.
   task automatic issue(input logic [NCH-1:0] m, output int e0);
      @(negedge clk);
      wr_done = 1'b1;
      wr_mask = m;
      @(negedge clk);
      wr_done = 1'b0;
      wr_mask = '0;
      e0 = cyc;
   endtask

   task automatic expect_ch(input int ch, input int pos, input int e0);
      q_cyc.push_back(e0 + 1 + (pos + 1) * S1 + S2 + S3);
      q_ch.push_back(ch);
      q_dat.push_back(x2_ref(int'(mem_x1[ch]), int'(mem_m[ch]), int'(mem_c[ch])));
   endtask

   task automatic expect_mask(input logic [NCH-1:0] m, input int e0);
      int pos = 0;
      for (int ch = 0; ch < NCH; ch++) begin
         if (m[ch]) begin
            expect_ch(ch, pos, e0);
            pos++;
         end
      end
   endtask

   task automatic wait_s1_idle(input int n, input int e0);
      while (stage1_busy) @(negedge clk);
      chk(cyc == e0 + 1 + n * S1, "R3 stage1 busy duration", cyc, e0 + 1 + n * S1);
   endtask

   task automatic accept_write(input logic [NCH-1:0] m, output int e0);
      issue(m, e0);
      expect_mask(m, e0);
      chk(stage1_busy == 1'b1, "R2 busy after accept", int'(stage1_busy), 1);
      chk(pipe_busy == 1'b1, "R2 pipe busy with stage1", int'(pipe_busy), 1);
   endtask

   task automatic set_ch(input int ch, input int x1, input int m, input int c);
      mem_x1[ch] = DW'(x1);
      mem_m[ch]  = DW'(m);
      mem_c[ch]  = DW'(c);
   endtask

   initial begin
      int e0, e1;
      logic [NCH-1:0] rm;
      void'($urandom(32'd4711));
      for (int ch = 0; ch < NCH; ch++) set_ch(ch, 0, 0, 8192);

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!stage1_busy && !pipe_busy && !x2_we && !wr_err, "R1 outputs in reset",
          int'({stage1_busy, pipe_busy, x2_we, wr_err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!stage1_busy && !pipe_busy && !x2_we && !wr_err, "R1 outputs after reset",
          int'({stage1_busy, pipe_busy, x2_we, wr_err}), 0);

      // R9: empty mask ignored
      issue('0, e0);
      chk(!stage1_busy && !wr_err, "R9 empty mask no busy or error",
          int'({stage1_busy, wr_err}), 0);
      @(negedge clk);
      chk(!pipe_busy && !wr_err, "R9 empty mask still idle", int'({pipe_busy, wr_err}), 0);

      // R5: unity gain, mid offset on one channel
      set_ch(2, 1000, 16383, 8192);
      accept_write(8'h04, e0);
      wait_s1_idle(1, e0);
      while (pipe_busy) @(negedge clk);

      // R5: saturation both ways plus a mid value, group write
      set_ch(0, 16383, 16383, 16383);
      set_ch(1, 0, 0, 0);
      set_ch(7, 12000, 8191, 5000);
      accept_write(8'h83, e0);
      wait_s1_idle(3, e0);

      // R7: accepted while stages 2 and 3 still work on channel 7
      chk(pipe_busy == 1'b1, "R7 later stages active", int'(pipe_busy), 1);
      set_ch(4, 321, 4000, 9000);
      accept_write(8'h10, e1);
      wait_s1_idle(1, e1);

      // R6: refused write during stage 1
      set_ch(3, 5555, 2222, 7000);
      set_ch(5, 1, 1, 1);
      accept_write(8'h0F, e0);
      repeat (10) @(negedge clk);
      issue(8'h30, e1);
      chk(wr_err == 1'b1, "R6 refusal flagged", int'(wr_err), 1);
      @(negedge clk);
      chk(wr_err == 1'b0, "R6 refusal flag one cycle", int'(wr_err), 0);
      wait_s1_idle(4, e0);
      while (pipe_busy) @(negedge clk);

      // R8: capture timing against storage updates
      set_ch(0, 4000, 12000, 8000);
      set_ch(3, 100, 100, 100);
      issue(8'h09, e0);
      expect_ch(0, 0, e0);
      repeat (3) @(negedge clk);
      set_ch(0, 9, 9, 9);
      set_ch(3, 15000, 3000, 12000);
      expect_ch(3, 1, e0);
      chk(rd_ch == CHW'(3), "R8 read select on next channel", int'(rd_ch), 3);
      wait_s1_idle(2, e0);

      // Random stimulus
      for (int it = 0; it < 30; it++) begin
         for (int ch = 0; ch < NCH; ch++)
            set_ch(ch, int'($urandom % 16384), int'($urandom % 16384), int'($urandom % 16384));
         rm = NCH'($urandom);
         if (rm == '0) rm = 8'h01;
         accept_write(rm, e0);
         if ($urandom % 3 == 0) begin
            repeat (1 + $urandom % 20) @(negedge clk);
            issue(NCH'($urandom) | 8'h01, e1);
            chk(wr_err == 1'b1, "R6 random refusal flagged", int'(wr_err), 1);
         end
         wait_s1_idle($countones(rm), e0);
         repeat ($urandom % 120) @(negedge clk);
      end

      while (pipe_busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(q_cyc.size() == 0, "R4 all results delivered", q_cyc.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule